// File: doc/BRIEF.md
# Bang-Bang Loop Lock Monitor

This block decides whether a bit-level phase-locked loop has settled. On each enabled cycle it takes the loop's three-level phase error code and reduces it to a single disagreement bit: 1 when the loop saw any error and 0 when the reconstructed clock matched the input. It then smooths that bit with a first-order exponential average held in an unsigned fixed-point register. A registered lock flag with two thresholds follows the smoothed rate. The flag sets when the rate drops under the lower threshold and clears only when the rate climbs over the upper threshold. Each change of the flag also produces a one-cycle pulse.

The error stream enters with `en` acting as its valid strobe. The block accepts every enabled sample in the cycle it is presented, so it has no ready signal and never applies back-pressure. It runs at full rate when `en` is tied high. The averaging shift and both thresholds are plain control inputs that are sampled live. Reset fills the average with full scale, meaning constant disagreement, so lock can only be reported after the loop has actually produced matching samples.

Top module: `pll_lock_monitor`

## Requirements
- R1: Error code 2'b00 gives a disagreement bit of 0. Codes 2'b01, 2'b11 and the illegal 2'b10 all give a disagreement bit of 1.
- R2: On each enabled cycle the average becomes avg + ((T - avg) >>> avg_shift), using signed arithmetic. T is all ones (2^W-1) when the disagreement bit is 1 and 0 when it is 0. The value of avg_shift may be any number from 0 to 15.
- R3: When `en` is low, the average and `locked` keep their values and `lock_chg` is 0.
- R4: `locked` goes from 0 to 1 after an enabled edge whose updated average is strictly below `thr_lo`.
- R5: `locked` goes from 1 to 0 only after an enabled edge whose updated average is strictly above `thr_hi`. An average between the two thresholds leaves `locked` as it is.
- R6: Synchronous reset loads the average with full scale and clears `locked` and `lock_chg`. After reset, one zero-error sample at shift 2 does not produce lock when `thr_lo` is 8192.
- R7: `lock_chg` is high for exactly the one cycle after each edge where `locked` changes, both on acquisition and on loss.
- R8: With `en` held high, every cycle is one sample, and the lock decision for a sample is visible right after the edge that takes it in.
- R9: The average never rises while the disagreement bit is 0 and never falls while it is 1, so it stays within 0 to 2^W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable and sample valid |
| err_code | input | 2 | Phase error code: 00 none, 01 lag, 11 lead, 10 illegal |
| avg_shift | input | 4 | Averaging shift k, where the time constant is about 2^k samples |
| thr_lo | input | W | Level below which lock is acquired |
| thr_hi | input | W | Level above which lock is lost |
| locked | output | 1 | Registered lock flag |
| lock_chg | output | 1 | One-cycle pulse on each lock change |

## Verification
Each result is due one edge after its sample. Both the updated average and the lock decision based on it are registered at the edge that takes in the sample, and `lock_chg` rises on that same edge. The bench changes inputs on the falling edge and reads outputs 1 ns after the rising edge. It advances its own model of the average and the flag exactly once per enabled edge and compares both outputs on every cycle. At the end of each stimulus segment it also compares `locked` against the value expected from the table.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic [1:0] {
    PD_MATCH = 2'b00,
    PD_LAG   = 2'b01,
    PD_BAD   = 2'b10,
    PD_LEAD  = 2'b11
  } pd_code_e;

  // Any code other than a match, the illegal one included, counts as disagreement.
  function automatic logic disagrees(input logic [1:0] code);
    return code != PD_MATCH;
  endfunction
endpackage

// File: rtl/err_indicator.sv
module err_indicator
  import pll_lock_pkg::*;
(
  input  logic [1:0] err_code,
  output logic       miss
);
  always_comb miss = disagrees(err_code);
endmodule

// File: rtl/ewma_avg.sv
module ewma_avg #(
  parameter int W       = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               miss,
  input  logic [SHIFT_W-1:0] shift,
  output logic [W-1:0]       avg_q,
  output logic [W-1:0]       avg_nxt
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic signed [W:0] target, cur, diff, step, sum;

  always_comb begin
    target  = miss ? $signed({1'b0, FULL}) : '0;
    cur     = $signed({1'b0, avg_q});
    diff    = target - cur;
    step    = diff >>> shift;
    sum     = cur + step;
    avg_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     avg_q <= FULL;
    else if (en) avg_q <= avg_nxt;
  end

  AST_AVG_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (en && !miss) |=> avg_q <= $past(avg_q));                        // R9
  AST_AVG_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    (en && miss) |=> avg_q >= $past(avg_q));                         // R9
  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(avg_q));                                         // R3
endmodule

// File: rtl/lock_hysteresis.sv
module lock_hysteresis #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] avg_in,
  input  logic [W-1:0] thr_lo,
  input  logic [W-1:0] thr_hi,
  output logic         locked,
  output logic         lock_chg
);
  logic lock_nxt;

  always_comb begin
    lock_nxt = locked;
    if (!locked && (avg_in < thr_lo))     lock_nxt = 1'b1;
    else if (locked && (avg_in > thr_hi)) lock_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      lock_chg <= 1'b0;
    end else if (en) begin
      locked   <= lock_nxt;
      lock_chg <= (lock_nxt != locked);
    end else begin
      lock_chg <= 1'b0;
    end
  end

  AST_LOCK_SET_BELOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked) && !$past(rst)) |-> ($past(avg_in) < $past(thr_lo)));   // R4
  AST_LOCK_CLR_ABOVE: assert property (@(posedge clk) disable iff (rst)
    ($fell(locked) && !$past(rst)) |-> ($past(avg_in) > $past(thr_hi)));   // R5
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (lock_chg && !$past(rst)) |-> (locked != $past(locked)));              // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(locked) && !lock_chg));                               // R3
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int W       = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [1:0]         err_code,
  input  logic [SHIFT_W-1:0] avg_shift,
  input  logic [W-1:0]       thr_lo,
  input  logic [W-1:0]       thr_hi,
  output logic               locked,
  output logic               lock_chg
);
  logic         miss;
  logic [W-1:0] avg_q;
  logic [W-1:0] avg_nxt;

  err_indicator u_ind (
    .err_code (err_code),
    .miss     (miss)
  );

  ewma_avg #(.W(W), .SHIFT_W(SHIFT_W)) u_avg (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .miss    (miss),
    .shift   (avg_shift),
    .avg_q   (avg_q),
    .avg_nxt (avg_nxt)
  );

  lock_hysteresis #(.W(W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .avg_in   (avg_nxt),
    .thr_lo   (thr_lo),
    .thr_hi   (thr_hi),
    .locked   (locked),
    .lock_chg (lock_chg)
  );

  AST_RESET_FULL: assert property (@(posedge clk)
    $past(rst) |-> (avg_q == {W{1'b1}} && !locked && !lock_chg));       // R6
endmodule

// File: tb/pll_lock_monitor_bench.sv
`timescale 1ns/1ps
module pll_lock_monitor_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [1:0]   err_code = 2'b00;
  logic [3:0]   avg_shift = 4'd2;
  logic [W-1:0] thr_lo = 16'd8192;
  logic [W-1:0] thr_hi = 16'd49152;
  logic         locked, lock_chg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_avg = 65535;
  bit m_lk = 1'b0;
  bit m_chg = 1'b0;

  always #4 clk = ~clk;

  pll_lock_monitor u_pll_lock_monitor (
    .clk(clk), .rst(rst), .en(en), .err_code(err_code), .avg_shift(avg_shift),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .locked(locked), .lock_chg(lock_chg)
  );

  typedef struct packed {
    logic        en;
    logic        alt;
    logic [1:0]  err;
    logic [3:0]  k;
    logic [15:0] n;
    logic        exp_lk;
  } seg_t;

  localparam int NSEG = 11;
  localparam seg_t SEGS [NSEG] = '{
    '{1'b1, 1'b0, 2'b00, 4'd2, 16'd60,  1'b1},
    '{1'b1, 1'b0, 2'b01, 4'd2, 16'd20,  1'b0},
    '{1'b1, 1'b0, 2'b00, 4'd2, 16'd60,  1'b1},
    '{1'b1, 1'b0, 2'b11, 4'd2, 16'd20,  1'b0},
    '{1'b1, 1'b0, 2'b00, 4'd2, 16'd60,  1'b1},
    '{1'b1, 1'b1, 2'b00, 4'd4, 16'd200, 1'b1},
    '{1'b1, 1'b0, 2'b10, 4'd2, 16'd20,  1'b0},
    '{1'b1, 1'b1, 2'b00, 4'd4, 16'd200, 1'b0},
    '{1'b0, 1'b0, 2'b00, 4'd2, 16'd100, 1'b0},
    '{1'b1, 1'b0, 2'b00, 4'd0, 16'd1,   1'b1},
    '{1'b1, 1'b0, 2'b01, 4'd0, 16'd1,   1'b0}
  };

  function automatic string seg_tag(input int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2: return "R8";
      3: return "R1";
      4: return "R9";
      5: return "R5";
      6: return "R1";
      7: return "R5";
      8: return "R3";
      9: return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Model per R2/R4/R5/R7: advance once per enabled edge.
  task automatic model_step(input bit e, input logic [1:0] err, input int k);
    int tgt, d;
    bit nl;
    if (!e) begin
      m_chg = 1'b0;
      return;
    end
    tgt = (err != 2'b00) ? 65535 : 0;
    d = tgt - m_avg;
    m_avg = m_avg + (d >>> k);
    nl = m_lk;
    if (!m_lk && m_avg < int'(thr_lo)) nl = 1'b1;
    else if (m_lk && m_avg > int'(thr_hi)) nl = 1'b0;
    m_chg = (nl != m_lk);
    m_lk = nl;
  endtask

  task automatic tick(input bit e, input logic [1:0] err, input logic [3:0] k, input string tag);
    @(negedge clk);
    en = e; err_code = err; avg_shift = k;
    @(posedge clk);
    #1;
    model_step(e, err, int'(k));
    check(tag, "locked", int'(locked), int'(m_lk));
    check(tag, "lock_chg", int'(lock_chg), int'(m_chg));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R6", "locked after reset", int'(locked), 0);
    check("R6", "lock_chg after reset", int'(lock_chg), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int s = 0; s < NSEG; s++) begin
      for (int c = 0; c < int'(SEGS[s].n); c++) begin
        logic [1:0] e2;
        e2 = SEGS[s].alt ? ((c % 2 == 1) ? 2'b01 : 2'b00) : SEGS[s].err;
        tick(SEGS[s].en, e2, SEGS[s].k, seg_tag(s));
      end
      check(seg_tag(s), "segment end lock", int'(locked), int'(SEGS[s].exp_lk));
    end

    // R6: mid-run reset restores full scale and clears lock.
    tick(1'b1, 2'b00, 4'd0, "R7");
    check("R7", "locked before reset", int'(locked), 1);
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(posedge clk);
    #1;
    m_avg = 65535; m_lk = 1'b0; m_chg = 1'b0;
    check("R6", "locked in reset", int'(locked), 0);
    check("R6", "lock_chg in reset", int'(lock_chg), 0);
    @(negedge clk);
    rst = 1'b0;
    tick(1'b1, 2'b00, 4'd2, "R6");
    check("R6", "no lock after first sample", int'(locked), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule